// File: doc/BRIEF.md
# Interlaced Field Raster Generator

This block produces the pixel-clock raster for interlaced output. It drives horizontal sync, a data-enable strobe, a field flag and a stream of framebuffer line addresses. A progressive framebuffer is split into two fields. The upper field (flag 0) fetches the even framebuffer lines and the lower field (flag 1) fetches the odd ones. Within a field, consecutive lines are two framebuffer lines apart. The lower field starts one stride after the base address.

Timing comes from input ports and is expected to be held steady while reset is released. The horizontal inputs are active, front porch, sync and back porch. The vertical inputs describe a whole frame: active lines plus front porch, sync and back porch lines. Each field shows half the frame's active lines and then a blanking stretch of half the frame's blanking lines, rounded down. The blanking that follows the upper field carries one extra line, so the two fields interleave on the screen. With 576 active and 49 blanking lines, the fields are 313 and 312 lines long. A line-fetch engine waits on the address strobe, and a separate sync generator may watch the field flag.

Top module: `ilace_raster_gen`

## Requirements
- R1: While reset is high, and in the first output cycle after it, de_o and addr_valid_o are 0, field_o is 0, addr_o is 0 and hsync_o sits at its idle level (equal to hsync_inv).
- R2: Each line lasts h_active+h_fp+h_sync+h_bp cycles. Counting the first active pixel of a line as cycle 0, horizontal sync is asserted for h_sync cycles starting at cycle h_active+h_fp.
- R3: With hsync_inv=0, hsync_o is high while sync is asserted and low otherwise. With hsync_inv=1, the levels are swapped, so sync is active low.
- R4: de_o is high exactly for cycles 0 to h_active-1 of each active line and low everywhere else, including every blanking line and the extra line.
- R5: Every field contains v_active/2 active lines, so a frame has v_active*h_active cycles with de_o high.
- R6: field_o is 0 after reset. It changes only when the first blanking line after a field's last active line begins, and it then takes the value of the field that comes next.
- R7: With B=v_fp+v_sync+v_bp, the blanking after the upper field (flag 0) lasts floor(B/2)+1 lines and the blanking after the lower field lasts floor(B/2) lines. The frame is v_active+2*floor(B/2)+1 lines long.
- R8: addr_valid_o is a one-cycle pulse on the first de_o cycle of every active line. It is never high on a blanking line.
- R9: When addr_valid_o is high on active line k of a field (k counted from 0), addr_o equals fb_base+2*k*fb_stride in the upper field and fb_base+fb_stride+2*k*fb_stride in the lower field.
- R10: Fields alternate without end: upper, lower, upper, and so on. The field flag changes twice per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| h_active | input | HW | Active pixels per line |
| h_fp | input | HW | Horizontal front porch, in pixels |
| h_sync | input | HW | Horizontal sync width, in pixels |
| h_bp | input | HW | Horizontal back porch, in pixels |
| v_active | input | VW | Active lines per frame (even) |
| v_fp | input | VW | Vertical front porch lines per frame |
| v_sync | input | VW | Vertical sync lines per frame |
| v_bp | input | VW | Vertical back porch lines per frame |
| hsync_inv | input | 1 | 1 makes horizontal sync active low |
| fb_base | input | AW | Framebuffer start address |
| fb_stride | input | AW | Address distance between framebuffer lines |
| hsync_o | output | 1 | Horizontal sync |
| de_o | output | 1 | Data enable for active pixels |
| field_o | output | 1 | Field flag, 0 upper and 1 lower |
| addr_valid_o | output | 1 | Line-address strobe |
| addr_o | output | AW | Framebuffer address of the current line |

## Verification
Two events can land in the same cycle: the vertical wrap into a new field and the address strobe for that field's first line. On that edge the address register reloads from the base plus the field offset, and it does not keep the doubled stride it was accumulating. The bench provokes this at every field start over several frames. It uses two geometries, one with an odd and one with an even blanking count, and base and stride values chosen so that an accumulated address and a reloaded address always differ. It checks every output in every cycle against a model built from the requirements. It also totals the data-enable cycles, the field toggles and the cycles the flag spends high in each run.

// File: rtl/ilace_pkg.sv
package ilace_pkg;
  parameter int unsigned ILC_HW = 12;
  parameter int unsigned ILC_VW = 11;
  parameter int unsigned ILC_AW = 32;

  typedef struct packed {
    logic de;
    logic sync;
    logic field;
    logic start;
  } ilc_beat_t;
endpackage

// File: rtl/ilace_hgen.sv
module ilace_hgen #(
  parameter int unsigned HW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] h_active,
  input  logic [HW-1:0] h_fp,
  input  logic [HW-1:0] h_sync,
  input  logic [HW-1:0] h_bp,
  output logic          line_end,
  output logic          line_start,
  output logic          pix_active,
  output logic          sync_active
);
  localparam int unsigned HCW = HW + 2;

  logic [HCW-1:0] hcnt;
  logic [HCW-1:0] htot;
  logic [HCW-1:0] sync_beg;
  logic [HCW-1:0] sync_end;

  always_comb begin
    htot     = {2'b00, h_active} + {2'b00, h_fp} + {2'b00, h_sync} + {2'b00, h_bp};
    sync_beg = {2'b00, h_active} + {2'b00, h_fp};
    sync_end = sync_beg + {2'b00, h_sync};
  end

  assign line_end    = (hcnt >= htot - HCW'(1));
  assign line_start  = (hcnt == '0);
  assign pix_active  = (hcnt < {2'b00, h_active});
  assign sync_active = (hcnt >= sync_beg) && (hcnt < sync_end);

  always_ff @(posedge clk) begin
    if (rst)           hcnt <= '0;
    else if (line_end) hcnt <= '0;
    else               hcnt <= hcnt + HCW'(1);
  end

  // R2: the pixel counter returns to zero right after the last pixel of a line
  p_hcnt_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    line_end |=> line_start);

  // R2: the pixel counter otherwise advances by one
  p_hcnt_step_r2: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> (hcnt == $past(hcnt) + HCW'(1)));
endmodule

// File: rtl/ilace_vgen.sv
module ilace_vgen #(
  parameter int unsigned VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_end,
  input  logic [VW-1:0] v_active,
  input  logic [VW-1:0] v_fp,
  input  logic [VW-1:0] v_sync,
  input  logic [VW-1:0] v_bp,
  output logic          field,
  output logic          line_active,
  output logic          wrap,
  output logic          act_line_end
);
  localparam int unsigned VCW = VW + 2;

  logic [VCW-1:0] vcnt;
  logic [VCW-1:0] field_act;
  logic [VCW-1:0] blank_half;
  logic [VCW-1:0] period_len;
  logic           last_act;

  always_comb begin
    field_act  = {2'b00, v_active} >> 1;
    blank_half = ({2'b00, v_fp} + {2'b00, v_sync} + {2'b00, v_bp}) >> 1;
    // the flag already names the next field; flag 1 means the upper field just ended
    period_len = field_act + blank_half + {{(VCW-1){1'b0}}, field};
  end

  assign line_active  = (vcnt < field_act);
  assign last_act     = (vcnt == field_act - VCW'(1));
  assign wrap         = line_end && (vcnt >= period_len - VCW'(1));
  assign act_line_end = line_end && line_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      vcnt  <= '0;
      field <= 1'b0;
    end else if (line_end) begin
      vcnt <= wrap ? '0 : vcnt + VCW'(1);
      if (last_act) field <= ~field;
    end
  end

  // R6: the flag flips when the first blanking line after the active lines begins
  p_field_flip_r6: assert property (@(posedge clk) disable iff (rst)
    (line_end && last_act) |=> (field != $past(field)));

  // R6: the flag holds at every other edge
  p_field_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(line_end && last_act) |=> $stable(field));

  // R7: a field period ends only inside its blanking stretch
  p_wrap_blank_r7: assert property (@(posedge clk) disable iff (rst)
    wrap |-> !line_active);
endmodule

// File: rtl/ilace_addr.sv
module ilace_addr #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] fb_base,
  input  logic [AW-1:0] fb_stride,
  input  logic          field,
  input  logic          wrap,
  input  logic          act_line_end,
  output logic [AW-1:0] line_addr
);
  logic [AW-1:0] stride2;
  logic [AW-1:0] start_addr;

  assign stride2    = {fb_stride[AW-2:0], 1'b0};
  assign start_addr = field ? (fb_base + fb_stride) : fb_base;

  always_ff @(posedge clk) begin
    if (rst)               line_addr <= fb_base;
    else if (wrap)         line_addr <= start_addr;
    else if (act_line_end) line_addr <= line_addr + stride2;
  end

  // R9: the line address moves only at a field start or after an active line
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(wrap || act_line_end) |=> $stable(line_addr));
endmodule

// File: rtl/ilace_raster_gen.sv
module ilace_raster_gen
  import ilace_pkg::*;
#(
  parameter int unsigned HW = ILC_HW,
  parameter int unsigned VW = ILC_VW,
  parameter int unsigned AW = ILC_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] h_active,
  input  logic [HW-1:0] h_fp,
  input  logic [HW-1:0] h_sync,
  input  logic [HW-1:0] h_bp,
  input  logic [VW-1:0] v_active,
  input  logic [VW-1:0] v_fp,
  input  logic [VW-1:0] v_sync,
  input  logic [VW-1:0] v_bp,
  input  logic          hsync_inv,
  input  logic [AW-1:0] fb_base,
  input  logic [AW-1:0] fb_stride,
  output logic          hsync_o,
  output logic          de_o,
  output logic          field_o,
  output logic          addr_valid_o,
  output logic [AW-1:0] addr_o
);
  logic          line_end, line_start, pix_active, sync_active;
  logic          field, line_active, wrap, act_line_end;
  logic [AW-1:0] line_addr;
  ilc_beat_t     beat;

  ilace_hgen #(.HW(HW)) u_hgen (
    .clk        (clk),
    .rst        (rst),
    .h_active   (h_active),
    .h_fp       (h_fp),
    .h_sync     (h_sync),
    .h_bp       (h_bp),
    .line_end   (line_end),
    .line_start (line_start),
    .pix_active (pix_active),
    .sync_active(sync_active)
  );

  ilace_vgen #(.VW(VW)) u_vgen (
    .clk         (clk),
    .rst         (rst),
    .line_end    (line_end),
    .v_active    (v_active),
    .v_fp        (v_fp),
    .v_sync      (v_sync),
    .v_bp        (v_bp),
    .field       (field),
    .line_active (line_active),
    .wrap        (wrap),
    .act_line_end(act_line_end)
  );

  ilace_addr #(.AW(AW)) u_addr (
    .clk         (clk),
    .rst         (rst),
    .fb_base     (fb_base),
    .fb_stride   (fb_stride),
    .field       (field),
    .wrap        (wrap),
    .act_line_end(act_line_end),
    .line_addr   (line_addr)
  );

  always_comb begin
    beat.de    = line_active && pix_active;
    beat.sync  = sync_active;
    beat.field = field;
    beat.start = line_active && line_start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o      <= hsync_inv;
      de_o         <= 1'b0;
      field_o      <= 1'b0;
      addr_valid_o <= 1'b0;
      addr_o       <= '0;
    end else begin
      hsync_o      <= beat.sync ^ hsync_inv;
      de_o         <= beat.de;
      field_o      <= beat.field;
      addr_valid_o <= beat.start;
      addr_o       <= line_addr;
    end
  end

  // R8: the address strobe marks the first enabled pixel of a line
  p_valid_first_px_r8: assert property (@(posedge clk) disable iff (rst)
    addr_valid_o |-> (de_o && !$past(de_o)));

  // R4: data enable never overlaps horizontal sync
  p_de_no_sync_r4: assert property (@(posedge clk) disable iff (rst)
    de_o |-> (hsync_o == hsync_inv));
endmodule

// File: tb/tb_ilace_raster_gen.sv
module tb_ilace_raster_gen;
  localparam int HW = 12;
  localparam int VW = 11;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [HW-1:0] h_active, h_fp, h_sync, h_bp;
  logic [VW-1:0] v_active, v_fp, v_sync, v_bp;
  logic          hsync_inv;
  logic [AW-1:0] fb_base, fb_stride;
  logic          hsync_o, de_o, field_o, addr_valid_o;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  ilace_raster_gen #(.HW(HW), .VW(VW), .AW(AW)) dut (
    .clk(clk), .rst(rst),
    .h_active(h_active), .h_fp(h_fp), .h_sync(h_sync), .h_bp(h_bp),
    .v_active(v_active), .v_fp(v_fp), .v_sync(v_sync), .v_bp(v_bp),
    .hsync_inv(hsync_inv), .fb_base(fb_base), .fb_stride(fb_stride),
    .hsync_o(hsync_o), .de_o(de_o), .field_o(field_o),
    .addr_valid_o(addr_valid_o), .addr_o(addr_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion earlier", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic configure(input int ha, input int hf, input int hs, input int hb,
                           input int va, input int vf, input int vs, input int vb,
                           input bit inv, input longint base, input longint stride);
    h_active = HW'(ha); h_fp = HW'(hf); h_sync = HW'(hs); h_bp = HW'(hb);
    v_active = VW'(va); v_fp = VW'(vf); v_sync = VW'(vs); v_bp = VW'(vb);
    hsync_inv = inv; fb_base = AW'(base); fb_stride = AW'(stride);
  endtask

  // R1: outputs while held in reset
  task automatic t_reset(input bit inv);
    @(negedge clk);
    rst = 1'b1;
    hsync_inv = inv;
    repeat (3) @(negedge clk);
    chk(de_o == 1'b0, "R1", "de in reset", de_o, 0);
    chk(addr_valid_o == 1'b0, "R1", "valid in reset", addr_valid_o, 0);
    chk(field_o == 1'b0, "R1", "field in reset", field_o, 0);
    chk(addr_o == '0, "R1", "addr in reset", addr_o, 0);
    chk(hsync_o == inv, "R1", "hsync idle in reset", hsync_o, inv);
  endtask

  // full-frame cycle model, compared every cycle (R2-R10)
  task automatic run_raster(input int frames);
    int ha, hf, hs, htot, fa, bh, p0, frame, ncyc;
    int de_cnt, tog_cnt, fld_hi;
    logic prev_fld;
    ha = int'(h_active); hf = int'(h_fp); hs = int'(h_sync);
    htot = ha + hf + hs + int'(h_bp);
    fa = int'(v_active) / 2;
    bh = (int'(v_fp) + int'(v_sync) + int'(v_bp)) / 2;
    p0 = fa + bh + 1;
    frame = 2 * fa + 2 * bh + 1;
    ncyc = frames * frame * htot;
    de_cnt = 0; tog_cnt = 0; fld_hi = 0; prev_fld = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int n = 0; n < ncyc; n++) begin
      int ln, px, fl, r, fa_of;
      bit act, e_de, e_av, e_fld, e_hs;
      longint e_addr;
      @(negedge clk);
      ln = n / htot; px = n % htot; fl = ln % frame;
      if (fl < p0) begin r = fl; fa_of = 0; end
      else begin r = fl - p0; fa_of = 1; end
      act = (r < fa);
      e_fld = act ? fa_of[0] : ~fa_of[0];
      e_de = act && (px < ha);
      e_av = act && (px == 0);
      e_hs = ((px >= ha + hf) && (px < ha + hf + hs)) ^ hsync_inv;
      e_addr = longint'(fb_base) + longint'(fa_of) * longint'(fb_stride)
               + 2 * longint'(r) * longint'(fb_stride);
      chk(de_o == e_de, "R4/R5", $sformatf("de line %0d px %0d", ln, px), de_o, e_de);
      chk(hsync_o == e_hs, "R2/R3", $sformatf("hsync line %0d px %0d", ln, px), hsync_o, e_hs);
      chk(field_o == e_fld, "R6/R7/R10", $sformatf("field line %0d", ln), field_o, e_fld);
      chk(addr_valid_o == e_av, "R8", $sformatf("valid line %0d px %0d", ln, px), addr_valid_o, e_av);
      if (e_av)
        chk(addr_o == AW'(e_addr), "R9", $sformatf("addr line %0d", ln), addr_o, e_addr);
      if (de_o) de_cnt++;
      if (field_o) fld_hi++;
      if (n > 0 && field_o != prev_fld) tog_cnt++;
      prev_fld = field_o;
    end
    chk(de_cnt == frames * int'(v_active) * ha, "R5", "enabled cycles", de_cnt,
        frames * int'(v_active) * ha);
    chk(tog_cnt == 2 * frames, "R10", "field toggles", tog_cnt, 2 * frames);
    chk(fld_hi == frames * (bh + 1 + fa) * htot, "R7", "cycles with flag high", fld_hi,
        frames * (bh + 1 + fa) * htot);
  endtask

  // odd blanking total, upright sync
  task automatic t_upright;
    configure(8, 2, 3, 3, 6, 1, 1, 3, 1'b0, 64'h1000, 64'h40);
    run_raster(3);
  endtask

  // inverted sync, other base and stride
  task automatic t_inverted;
    configure(8, 2, 3, 3, 6, 1, 1, 3, 1'b1, 64'h2_0000, 64'h300);
    run_raster(3);
  endtask

  // even blanking total, tighter line
  task automatic t_compact;
    configure(6, 1, 2, 1, 4, 2, 2, 2, 1'b0, 64'h500, 64'h18);
    run_raster(4);
  endtask

  initial begin
    configure(8, 2, 3, 3, 6, 1, 1, 3, 1'b0, 64'h1000, 64'h40);
    t_reset(1'b0);
    t_reset(1'b1);
    t_upright();
    t_inverted();
    t_compact();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule